// File: doc/BRIEF.md
# Interrupt Controller Reset-State Register File

This block is the small register file of a per-core interrupt controller, seen from the angle of its reset behaviour. It holds the controller's identifier, an arbitration identifier, a parameterised set of local vector table (LVT) entries, a software-enable control bit and a hardwired version word. Software reaches all of it through a single-cycle register port with a combinational read.

Three reset-like events act on it. A hardware reset (synchronous, active low) puts everything back to power-up values, with both identifiers loaded from a strap input. An INIT comes from either a dedicated pin or a decoded inter-processor message. It restores every register except the two identifiers and raises a wait-for-startup status, which a later startup message clears. An INIT-deassert message only copies the identifier into the arbitration identifier. Until software sets the enable bit, the LVT mask bits cannot be cleared.

Top module: `irq_rst_regfile`

## Requirements
- R1: After hardware reset, ID (address 0) and arbitration ID (address 1) read the strap value, CTRL (address 3) reads 0, every LVT entry (addresses 4 to 4+N_LVT-1) reads mask bit 16 set and vector bits 7:0 zero, and `wait_startup` is 0.
- R2: Address 2 reads the version word: 0x14 in bits 7:0, N_LVT-1 in bits 23:16 (0x00050014 for six entries), other bits zero; writes to it change nothing.
- R3: While CTRL bit 0 is 0, a write to an LVT entry stores bits 7:0 but cannot clear its mask bit 16.
- R4: Once CTRL bit 0 is 1, LVT mask bits follow written bit 16 in both directions.
- R5: An INIT (`init_pin` high, or `msg_valid` with `msg_mode` 3'b101) returns CTRL and every LVT entry to reset values at the next edge; ID and arbitration ID keep their contents, and a register write in the same cycle is dropped.
- R6: `wait_startup` is 1 from the cycle after any INIT; a message with `msg_mode` 3'b110 clears it, unless an INIT arrives in the same cycle.
- R7: An INIT-deassert message (`msg_mode` 3'b111) loads the arbitration ID with the ID value held before that edge, and leaves every other register and `wait_startup` unchanged. The load also happens alongside a pin INIT.
- R8: The arbitration ID is read-only to software; ID bits ID_W-1:0 are writable.
- R9: Hardware reset takes priority over a simultaneous INIT and reloads both identifiers from `strap_id`.
- R10: Messages with `msg_valid` low or with modes 3'b000 to 3'b100 have no effect; unmapped addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| strap_id | input | ID_W | Identifier loaded at hardware reset |
| init_pin | input | 1 | INIT request, active high |
| msg_valid | input | 1 | Decoded message present this cycle |
| msg_mode | input | 3 | Delivery mode of the message |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| wait_startup | output | 1 | Waiting for a startup message after INIT |

## Verification
A wrong internal state appears on `reg_rdata` as soon as the bench addresses the affected register. This is the edge after the event for INIT, INIT-deassert and lock faults. A dropped or spurious wait-for-startup transition shows on `wait_startup` in that same cycle. An arbitration ID copied from the written value instead of the held one differs from the model only in the cycle that combines an ID write with a deassert, so that combination is driven explicitly. A mask bit freed too early shows only when a write tries to clear it while locked.

// File: rtl/irq_rst_pkg.sv
`timescale 1ns/1ps
package irq_rst_pkg;
  localparam int REG_W    = 32;
  localparam int VEC_W    = 8;
  localparam int MASK_POS = 16;
  localparam logic [7:0] CORE_VERSION = 8'h14;

  typedef enum logic [2:0] {
    DM_NORMAL     = 3'd0,
    DM_LOWPRI     = 3'd1,
    DM_SYSMGMT    = 3'd2,
    DM_SPARE      = 3'd3,
    DM_NONMASK    = 3'd4,
    DM_INIT       = 3'd5,
    DM_STARTUP    = 3'd6,
    DM_INIT_DEASS = 3'd7
  } dmode_e;

  // Version word: revision in the low byte, entry count minus one in byte 2.
  function automatic logic [REG_W-1:0] version_word(input int unsigned n_entries);
    logic [REG_W-1:0] w;
    w        = '0;
    w[7:0]   = CORE_VERSION;
    w[23:16] = 8'(n_entries - 1);
    return w;
  endfunction

  // While locked a mask bit may only be set, never cleared.
  function automatic logic mask_next(input logic cur, input logic req, input logic locked);
    return locked ? (cur | req) : req;
  endfunction

  function automatic logic [REG_W-1:0] lvt_word(input logic [VEC_W-1:0] vec, input logic mask);
    logic [REG_W-1:0] w;
    w           = '0;
    w[VEC_W-1:0] = vec;
    w[MASK_POS] = mask;
    return w;
  endfunction
endpackage

// File: rtl/irq_evt_decode.sv
`timescale 1ns/1ps
module irq_evt_decode
  import irq_rst_pkg::*;
(
  input  logic       init_pin,
  input  logic       msg_valid,
  input  logic [2:0] msg_mode,
  output logic       init_evt,
  output logic       deassert_evt,
  output logic       startup_evt
);
  logic msg_init;

  assign msg_init     = msg_valid && (msg_mode == DM_INIT);
  assign init_evt     = init_pin || msg_init;
  assign deassert_evt = msg_valid && (msg_mode == DM_INIT_DEASS);
  assign startup_evt  = msg_valid && (msg_mode == DM_STARTUP);
endmodule

// File: rtl/irq_id_regs.sv
`timescale 1ns/1ps
module irq_id_regs #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] strap_id,
  input  logic            init_evt,
  input  logic            deassert_evt,
  input  logic            id_we,
  input  logic [ID_W-1:0] id_wdata,
  output logic [ID_W-1:0] id_q,
  output logic [ID_W-1:0] arb_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q  <= strap_id;
      arb_q <= strap_id;
    end else begin
      if (id_we && !init_evt) id_q <= id_wdata;
      if (deassert_evt)       arb_q <= id_q;
    end
  end
endmodule

// File: rtl/irq_ctrl_state.sv
`timescale 1ns/1ps
module irq_ctrl_state (
  input  logic clk,
  input  logic rst_n,
  input  logic init_evt,
  input  logic startup_evt,
  input  logic ctrl_we,
  input  logic ctrl_wbit,
  output logic sw_en,
  output logic wait_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_en  <= 1'b0;
      wait_q <= 1'b0;
    end else if (init_evt) begin
      sw_en  <= 1'b0;
      wait_q <= 1'b1;
    end else begin
      if (ctrl_we)     sw_en  <= ctrl_wbit;
      if (startup_evt) wait_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_lvt_bank.sv
`timescale 1ns/1ps
module irq_lvt_bank
  import irq_rst_pkg::*;
#(
  parameter int N_LVT  = 6,
  parameter int ADDR_W = 4,
  parameter int BASE   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        init_evt,
  input  logic                        locked,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [VEC_W-1:0]            wvec,
  input  logic                        wmask,
  output logic [N_LVT-1:0][VEC_W-1:0] vec_o,
  output logic [N_LVT-1:0]            mask_o
);
  for (genvar g = 0; g < N_LVT; g++) begin : g_ent
    logic             hit;
    logic [VEC_W-1:0] vec_q;
    logic             mask_q;

    assign hit = we && (addr == ADDR_W'(BASE + g));

    always_ff @(posedge clk) begin
      if (!rst_n || init_evt) begin
        vec_q  <= '0;
        mask_q <= 1'b1;
      end else if (hit) begin
        vec_q  <= wvec;
        mask_q <= mask_next(mask_q, wmask, locked);
      end
    end

    assign vec_o[g]  = vec_q;
    assign mask_o[g] = mask_q;
  end
endmodule

// File: rtl/irq_rst_regfile.sv
`timescale 1ns/1ps
module irq_rst_regfile
  import irq_rst_pkg::*;
#(
  parameter int N_LVT  = 6,
  parameter int ID_W   = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   strap_id,
  input  logic              init_pin,
  input  logic              msg_valid,
  input  logic [2:0]        msg_mode,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              wait_startup
);
  localparam int A_ID   = 0;
  localparam int A_ARB  = 1;
  localparam int A_VER  = 2;
  localparam int A_CTRL = 3;
  localparam int A_LVT0 = 4;

  // Named internal events, observed by the bound checker.
  logic                        init_evt;
  logic                        deassert_evt;
  logic                        startup_evt;
  logic                        sw_en;
  logic                        sw_locked;
  logic [ID_W-1:0]             id_q;
  logic [ID_W-1:0]             arb_q;
  logic [N_LVT-1:0][VEC_W-1:0] lvt_vec;
  logic [N_LVT-1:0]            mask_vec;
  logic                        id_we;
  logic                        ctrl_we;
  logic                        unused_wdata;

  assign id_we        = reg_we && (reg_addr == ADDR_W'(A_ID));
  assign ctrl_we      = reg_we && (reg_addr == ADDR_W'(A_CTRL));
  assign sw_locked    = !sw_en;
  assign unused_wdata = ^reg_wdata;

  irq_evt_decode u_dec (
    .init_pin     (init_pin),
    .msg_valid    (msg_valid),
    .msg_mode     (msg_mode),
    .init_evt     (init_evt),
    .deassert_evt (deassert_evt),
    .startup_evt  (startup_evt)
  );

  irq_id_regs #(.ID_W(ID_W)) u_ids (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_id     (strap_id),
    .init_evt     (init_evt),
    .deassert_evt (deassert_evt),
    .id_we        (id_we),
    .id_wdata     (reg_wdata[ID_W-1:0]),
    .id_q         (id_q),
    .arb_q        (arb_q)
  );

  irq_ctrl_state u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_evt    (init_evt),
    .startup_evt (startup_evt),
    .ctrl_we     (ctrl_we),
    .ctrl_wbit   (reg_wdata[0]),
    .sw_en       (sw_en),
    .wait_q      (wait_startup)
  );

  irq_lvt_bank #(.N_LVT(N_LVT), .ADDR_W(ADDR_W), .BASE(A_LVT0)) u_lvt (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_evt (init_evt),
    .locked   (sw_locked),
    .we       (reg_we),
    .addr     (reg_addr),
    .wvec     (reg_wdata[VEC_W-1:0]),
    .wmask    (reg_wdata[MASK_POS]),
    .vec_o    (lvt_vec),
    .mask_o   (mask_vec)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_ID))        reg_rdata[ID_W-1:0] = id_q;
    else if (reg_addr == ADDR_W'(A_ARB))  reg_rdata[ID_W-1:0] = arb_q;
    else if (reg_addr == ADDR_W'(A_VER))  reg_rdata = version_word(N_LVT);
    else if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata[0] = sw_en;
    for (int i = 0; i < N_LVT; i++) begin
      if (reg_addr == ADDR_W'(A_LVT0 + i)) reg_rdata = lvt_word(lvt_vec[i], mask_vec[i]);
    end
  end
endmodule

// File: rtl/irq_rst_regfile_chk.sv
`timescale 1ns/1ps
module irq_rst_regfile_chk #(
  parameter int N_LVT = 6,
  parameter int ID_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_evt,
  input logic             deassert_evt,
  input logic             startup_evt,
  input logic             sw_locked,
  input logic             reg_we,
  input logic [N_LVT-1:0] mask_vec,
  input logic [ID_W-1:0]  id_q,
  input logic [ID_W-1:0]  arb_q,
  input logic             wait_startup
);
  p_masks_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> (mask_vec == {N_LVT{1'b1}}));

  p_id_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> $stable(id_q));

  p_wait_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> wait_startup);

  p_wait_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (startup_evt && !init_evt) |=> !wait_startup);

  p_lock_no_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_locked |=> (($past(mask_vec) & ~mask_vec) == '0));

  p_arb_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    deassert_evt |=> (arb_q == $past(id_q)));

  p_deassert_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (deassert_evt && !init_evt && !reg_we) |=>
      ($stable(mask_vec) && $stable(wait_startup) && $stable(id_q) && $stable(sw_locked)));
endmodule

bind irq_rst_regfile irq_rst_regfile_chk #(.N_LVT(N_LVT), .ID_W(ID_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .init_evt     (init_evt),
  .deassert_evt (deassert_evt),
  .startup_evt  (startup_evt),
  .sw_locked    (sw_locked),
  .reg_we       (reg_we),
  .mask_vec     (mask_vec),
  .id_q         (id_q),
  .arb_q        (arb_q),
  .wait_startup (wait_startup)
);

// File: tb/irq_rst_regfile_tb.sv
`timescale 1ns/1ps
module irq_rst_regfile_tb;
  localparam int NL = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  strap_id = 8'h3A;
  logic        init_pin = 1'b0;
  logic        msg_valid = 1'b0;
  logic [2:0]  msg_mode = 3'd0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        wait_startup;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // Behavioural reference model
  int m_id, m_arb, m_en, m_ws, old_id;
  int m_vec [NL];
  int m_mask[NL];
  bit ev_init, ev_dea, ev_st;

  irq_rst_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .strap_id(strap_id), .init_pin(init_pin),
    .msg_valid(msg_valid), .msg_mode(msg_mode), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wait_startup(wait_startup)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_id = strap_id; m_arb = strap_id; m_en = 0; m_ws = 0;
      for (int i = 0; i < NL; i++) begin m_vec[i] = 0; m_mask[i] = 1; end
    end else begin
      ev_init = init_pin || (msg_valid && msg_mode == 3'd5);
      ev_dea  = msg_valid && msg_mode == 3'd7;
      ev_st   = msg_valid && msg_mode == 3'd6;
      old_id  = m_id;
      if (ev_init) begin
        m_en = 0; m_ws = 1;
        for (int i = 0; i < NL; i++) begin m_vec[i] = 0; m_mask[i] = 1; end
      end else begin
        if (reg_we) begin
          if (reg_addr == 0) m_id = reg_wdata[7:0];
          else if (reg_addr == 3) m_en = reg_wdata[0];
          else if (reg_addr >= 4 && reg_addr < 4 + NL) begin
            m_vec[reg_addr-4] = reg_wdata[7:0];
            if (m_en == 0) m_mask[reg_addr-4] = m_mask[reg_addr-4] | reg_wdata[16];
            else m_mask[reg_addr-4] = reg_wdata[16];
          end
        end
        if (ev_st) m_ws = 0;
      end
      if (ev_dea) m_arb = old_id;
    end
  end

  function automatic logic [31:0] ref_read(input int a);
    if (a == 0) return 32'(m_id);
    if (a == 1) return 32'(m_arb);
    if (a == 2) return 32'h0005_0014;
    if (a == 3) return 32'(m_en);
    if (a >= 4 && a < 4 + NL) return 32'(m_vec[a-4]) | (32'(m_mask[a-4]) << 16);
    return 32'h0;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // Compare every register and the status output against the model.
  task automatic sweep();
    string tag;
    reg_we = 1'b0;
    check(cur_req, "wait_startup", {31'd0, wait_startup}, 32'(m_ws));
    for (int a = 0; a < 16; a++) begin
      reg_addr = 4'(a);
      #0.1;
      tag = (a == 2) ? "R2" : (a >= 4 + NL) ? "R10" : cur_req;
      check(tag, $sformatf("addr %0d", a), reg_rdata, ref_read(a));
    end
  endtask

  task automatic cyc(input bit ip, input bit mv, input logic [2:0] mm,
                     input bit we, input int addr, input logic [31:0] wd);
    init_pin = ip; msg_valid = mv; msg_mode = mm;
    reg_we = we; reg_addr = 4'(addr); reg_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    init_pin = 1'b0; msg_valid = 1'b0; reg_we = 1'b0;
    sweep();
  endtask

  task automatic hw_reset();
    rst_n = 1'b0; init_pin = 1'b1;  // R9: INIT held during reset
    msg_valid = 1'b1; msg_mode = 3'd5;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; init_pin = 1'b0; msg_valid = 1'b0;
    sweep();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cur_req = "R1"; hw_reset();
    cur_req = "R2"; cyc(0, 0, 0, 1, 2, 32'hFFFF_FFFF);
    cur_req = "R3"; cyc(0, 0, 0, 1, 4, 32'h0000_00AB);
    cyc(0, 0, 0, 1, 9, 32'h0001_0011);
    cyc(0, 0, 0, 1, 5, 32'h0000_0000);
    cur_req = "R8"; cyc(0, 0, 0, 1, 0, 32'h0000_0077);
    cyc(0, 0, 0, 1, 1, 32'h0000_0012);
    cur_req = "R4"; cyc(0, 0, 0, 1, 3, 32'h0000_0001);
    cyc(0, 0, 0, 1, 4, 32'h0000_0055);
    cyc(0, 0, 0, 1, 5, 32'h0000_0000);
    cyc(0, 0, 0, 1, 5, 32'h0001_0000);
    cyc(0, 0, 0, 1, 6, 32'h0000_00C3);
    cur_req = "R7"; cyc(0, 1, 3'd7, 0, 0, 0);
    cyc(0, 1, 3'd7, 1, 0, 32'h0000_0088);  // arb takes 0x77, id becomes 0x88
    cyc(0, 1, 3'd7, 0, 0, 0);
    cur_req = "R5"; cyc(0, 1, 3'd5, 1, 0, 32'h0000_0099);
    cyc(0, 0, 0, 0, 0, 0);
    cur_req = "R6"; cyc(1, 1, 3'd6, 0, 0, 0);
    cyc(0, 1, 3'd6, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cur_req = "R5"; cyc(0, 0, 0, 1, 3, 32'h0000_0001);
    cyc(0, 0, 0, 1, 7, 32'h0000_0042);
    cyc(1, 0, 0, 1, 8, 32'h0000_0033);
    cyc(0, 0, 0, 1, 8, 32'h0000_0033);
    cur_req = "R7"; cyc(0, 0, 0, 1, 0, 32'h0000_00E1);
    cyc(1, 1, 3'd7, 1, 0, 32'h0000_00F2);
    cur_req = "R10";
    for (int m = 0; m < 5; m++) cyc(0, 1, 3'(m), 0, 0, 0);
    cyc(0, 0, 3'd5, 0, 0, 0);
    cyc(0, 0, 3'd7, 1, 12, 32'hFFFF_FFFF);
    cyc(0, 0, 3'd6, 1, 15, 32'hFFFF_FFFF);
    cur_req = "R9"; strap_id = 8'h5C; hw_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule